// File: doc/BRIEF.md
# Reset Line Active Pull-Up Sequencer

This block drives the pull-up side of a shared, active-low reset line that several devices may pull low. Two sampled comparator flags report the line level: one is set while the line sits below a low threshold, the other while it sits above that threshold on the way up. When the line has stayed low for a qualifying number of clock cycles, an arming flag is set. The next rising crossing then starts a one-shot of fixed length in clock cycles. During the one-shot an active pull-up is enabled so the line's low-to-high edge is fast even with a heavy load. When the one-shot ends, the active pull-up switches off and the arming flag clears.

The block also turns its own reset requests into a pulldown enable. Each request bit comes from a separate source, such as a supply monitor or a manual input. While the pulldown is on, the passive pull-up is disconnected. The arm-and-fire sequence is the same whatever pulled the line low: one of the block's own request sources, or another device on the line.

Top module: `rstpu_seq`

## Requirements
- R1: After `line_below` has been sampled high on SETUP_CYC consecutive rising clock edges (default 4), `line_armed` reads 1 from the following cycle on.
- R2: A low excursion of fewer than SETUP_CYC consecutive samples does not set `line_armed`, and a later rising level then does not start the one-shot.
- R3: While `line_armed` is 1, `line_below` is 0, no request bit is set and `pd_en` is 0, a sampled `line_above` of 1 starts the one-shot. `active_pu_en` is then 1 for exactly PULSE_CYC cycles (default 100), starting the cycle after that edge.
- R4: On the edge where the one-shot ends by expiry, `active_pu_en` returns to 0 and `line_armed` clears. A new qualifying low on that same edge takes priority and keeps it set.
- R5: `line_above` seen while `line_armed` is 0 leaves `active_pu_en` at 0.
- R6: `pd_en` equals the OR of `own_req` as sampled on the previous edge. Bit 0 is the supply-monitor request and bit 1 is the manual request, both active high. `passive_pu_en` is always the inverse of `pd_en`.
- R7: `active_pu_en` and `pd_en` are never 1 together. A request arriving during the one-shot ends it on the next edge and leaves `line_armed` set.
- R8: While `rst_n` is low, `pd_en`, `active_pu_en` and `line_armed` are 0 and `passive_pu_en` is 1.
- R9: The arm-and-fire sequence gives the same pulse whether the low came from the supply request, the manual request, or only from an external device pulling the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_req | input | NUM_SRC | Own reset requests (bit 0 supply, bit 1 manual), active high |
| line_below | input | 1 | Sampled flag: line below the low threshold |
| line_above | input | 1 | Sampled flag: line above the threshold, rising |
| pd_en | output | 1 | Enable for the internal pulldown |
| passive_pu_en | output | 1 | Enable for the passive pull-up resistor |
| active_pu_en | output | 1 | Enable for the active pull-up (one-shot) |
| line_armed | output | 1 | Transition flip-flop: a qualified low has been seen |

## Verification
The assertions assume that `line_below` and `line_above` are never 1 together, because both flags come from one threshold on a single line. They also assume that the flags and `own_req` are already synchronous to `clk`. The stimulus keeps to these assumptions: it changes every input only at the falling clock edge, and it never raises the two level flags at the same time. When a request is active, the stimulus also drives the line low, as the real pulldown would. Between a release and a rising crossing it passes through a cycle in which neither flag is set.

// File: rtl/rstpu_pkg.sv
package rstpu_pkg;

  // Number of the current consecutive low sample (1-based) reaches the
  // qualifying count.
  function automatic bit low_qualified(int prior_run, int need);
    return (prior_run + 1) >= need;
  endfunction

  // Saturating next value for a run counter.
  function automatic int run_next(int prior_run, int cap);
    return (prior_run >= cap) ? cap : prior_run + 1;
  endfunction

  // Reload value of a down-counting one-shot lasting len cycles.
  function automatic int shot_reload(int len);
    return len - 1;
  endfunction

endpackage

// File: rtl/rstpu_low_qual.sv
module rstpu_low_qual #(
  parameter int SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_below,
  output logic arm_set
);
  import rstpu_pkg::*;

  generate
    if (SETUP_CYC <= 1) begin : g_direct
      assign arm_set = line_below;
    end else begin : g_count
      localparam int CW  = $clog2(SETUP_CYC + 1);
      localparam int CAP = SETUP_CYC - 1;
      logic [CW-1:0] run_q;
      logic [CW-1:0] run_d;

      always_comb begin
        if (line_below) run_d = CW'(run_next(int'(run_q), CAP));
        else            run_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
      end

      assign arm_set = line_below && low_qualified(int'(run_q), SETUP_CYC);
    end
  endgenerate

endmodule

// File: rtl/rstpu_oneshot.sv
module rstpu_oneshot #(
  parameter int PULSE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic abort,
  output logic active,
  output logic expire
);
  import rstpu_pkg::*;

  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic [CW-1:0] left_q;
  logic          on_q;

  assign expire = on_q && !abort && (left_q == '0);
  assign active = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else if (abort) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else if (on_q) begin
      if (left_q == '0) on_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (fire) begin
      on_q   <= 1'b1;
      left_q <= CW'(shot_reload(PULSE_CYC));
    end
  end

endmodule

// File: rtl/rstpu_drive.sv
module rstpu_drive #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] own_req,
  output logic               drive_any,
  output logic               pd_en,
  output logic               passive_pu_en
);

  logic [NUM_SRC-1:0] req_or;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_or
      if (i == 0) begin : g_first
        assign req_or[i] = own_req[i];
      end else begin : g_rest
        assign req_or[i] = req_or[i-1] | own_req[i];
      end
    end
  endgenerate

  assign drive_any = req_or[NUM_SRC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_en <= 1'b0;
    else        pd_en <= drive_any;
  end

  assign passive_pu_en = !pd_en;

endmodule

// File: rtl/rstpu_seq.sv
module rstpu_seq #(
  parameter int NUM_SRC   = 2,
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] own_req,
  input  logic               line_below,
  input  logic               line_above,
  output logic               pd_en,
  output logic               passive_pu_en,
  output logic               active_pu_en,
  output logic               line_armed
);

  // Named internal events, visible to the bound checker.
  logic drive_any;
  logic arm_set;
  logic shot_fire;
  logic shot_expire;
  logic armed_q;

  rstpu_drive #(.NUM_SRC(NUM_SRC)) u_drive (
    .clk           (clk),
    .rst_n         (rst_n),
    .own_req       (own_req),
    .drive_any     (drive_any),
    .pd_en         (pd_en),
    .passive_pu_en (passive_pu_en)
  );

  rstpu_low_qual #(.SETUP_CYC(SETUP_CYC)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_below (line_below),
    .arm_set    (arm_set)
  );

  assign shot_fire = armed_q && line_above && !line_below && !drive_any && !pd_en;

  rstpu_oneshot #(.PULSE_CYC(PULSE_CYC)) u_shot (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (shot_fire),
    .abort  (drive_any),
    .active (active_pu_en),
    .expire (shot_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (arm_set)     armed_q <= 1'b1;
    else if (shot_expire) armed_q <= 1'b0;
  end

  assign line_armed = armed_q;

endmodule

// File: rtl/rstpu_seq_chk.sv
module rstpu_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_any,
  input logic arm_set,
  input logic pd_en,
  input logic passive_pu_en,
  input logic active_pu_en,
  input logic line_armed
);

  AST_ARM_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> line_armed); // R1

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_pu_en) |-> $past(line_armed)); // R5

  AST_EXPIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active_pu_en) && !$past(drive_any) && !$past(arm_set)) |-> !line_armed); // R4

  AST_REQ_TO_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    drive_any |=> pd_en); // R6

  AST_PASSIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> !passive_pu_en); // R6

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_pu_en && pd_en)); // R7

  AST_ABORT_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (active_pu_en && drive_any) |=> (!active_pu_en && line_armed)); // R7

endmodule

bind rstpu_seq rstpu_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .drive_any     (drive_any),
  .arm_set       (arm_set),
  .pd_en         (pd_en),
  .passive_pu_en (passive_pu_en),
  .active_pu_en  (active_pu_en),
  .line_armed    (line_armed)
);

// File: tb/rstpu_seq_bench.sv
`timescale 1ns/1ps
module rstpu_seq_bench;
  localparam int SETUP = 4;
  localparam int PULSE = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = 2'b00;
  logic       below = 1'b0;
  logic       above = 1'b0;
  logic       pd_en, passive_pu_en, active_pu_en, line_armed;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rstpu_seq #(.NUM_SRC(2), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)) u_rstpu_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .own_req       (req),
    .line_below    (below),
    .line_above    (above),
    .pd_en         (pd_en),
    .passive_pu_en (passive_pu_en),
    .active_pu_en  (active_pu_en),
    .line_armed    (line_armed)
  );

  // Behavioural reference model.
  int m_low = 0;
  int m_shot = 0;
  bit m_arm = 1'b0;
  bit m_pd = 1'b0;

  always @(posedge clk or negedge rst_n) begin : model
    bit drv, set, expire;
    if (!rst_n) begin
      m_low = 0; m_shot = 0; m_arm = 1'b0; m_pd = 1'b0;
    end else begin
      drv = |req;
      expire = 1'b0;
      m_low = below ? m_low + 1 : 0;
      if (m_low > 1000) m_low = 1000;
      set = below && (m_low >= SETUP);
      if (drv) m_shot = 0;
      else if (m_shot > 0) begin
        m_shot = m_shot - 1;
        if (m_shot == 0) expire = 1'b1;
      end else if (m_arm && above && !below && !m_pd) m_shot = PULSE;
      if (set) m_arm = 1'b1;
      else if (expire) m_arm = 1'b0;
      m_pd = drv;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one cycle; compare every output with the model at the falling edge.
  task automatic step();
    @(negedge clk);
    check("R6 pd_en", pd_en, m_pd);
    check("R6 passive_pu_en", passive_pu_en, !m_pd);
    check("R3 active_pu_en", active_pu_en, (m_shot > 0));
    check("R1 line_armed", line_armed, m_arm);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Count active cycles across a window.
  task automatic count_active(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (active_pu_en) c++;
    end
  endtask

  initial begin : stim
    int c;
    run(3);
    check("R8 reset pd_en", pd_en, 0);
    check("R8 reset passive", passive_pu_en, 1);
    check("R8 reset active", active_pu_en, 0);
    check("R8 reset armed", line_armed, 0);
    rst_n = 1'b1;
    run(2);

    // R5: rising level without arming
    above = 1'b1;
    count_active(10, c);
    check("R5 unarmed rise", c, 0);
    above = 1'b0;
    run(2);

    // R2: glitch one sample short of setup
    below = 1'b1;
    run(SETUP - 1);
    below = 1'b0;
    run(2);
    check("R2 glitch no arm", line_armed, 0);
    above = 1'b1;
    count_active(8, c);
    check("R2 no fire after glitch", c, 0);
    above = 1'b0;
    run(2);

    // R1/R3/R4/R9: external device pulls line low
    below = 1'b1;
    run(SETUP);
    check("R1 armed after setup", line_armed, 1);
    run(2);
    below = 1'b0;
    run(2);
    check("R1 armed held", line_armed, 1);
    above = 1'b1;
    count_active(PULSE + 6, c);
    check("R3 R9 external pulse length", c, PULSE);
    check("R4 disarmed after expiry", line_armed, 0);
    above = 1'b0;
    run(2);

    // R6/R9: manual request
    req = 2'b10;
    step();
    check("R6 manual pd_en", pd_en, 1);
    check("R6 manual passive off", passive_pu_en, 0);
    below = 1'b1;
    run(8);
    req = 2'b00;
    step();
    check("R6 pd released", pd_en, 0);
    below = 1'b0;
    step();
    above = 1'b1;
    count_active(PULSE + 6, c);
    check("R9 manual pulse length", c, PULSE);
    above = 1'b0;
    run(2);

    // R7: supply request aborts one-shot
    req = 2'b01;
    below = 1'b1;
    run(8);
    req = 2'b00;
    step();
    below = 1'b0;
    step();
    above = 1'b1;
    run(10);
    check("R7 pulse running", active_pu_en, 1);
    req = 2'b01;
    above = 1'b0;
    step();
    check("R7 abort active", active_pu_en, 0);
    check("R7 pd on", pd_en, 1);
    check("R7 armed kept", line_armed, 1);
    below = 1'b1;
    run(4);
    req = 2'b00;
    step();
    below = 1'b0;
    step();
    above = 1'b1;
    count_active(PULSE + 6, c);
    check("R9 supply pulse length", c, PULSE);
    check("R4 disarmed after supply pulse", line_armed, 0);
    above = 1'b0;
    run(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule